// File: doc/BRIEF.md
# Power Switch Protection Supervisor

This block is the digital decision core beside a high-side load switch. It receives condition flags that analog comparators have already turned into logic levels: an enable request, input undervoltage, current limiting in progress, output driven above input, die temperature past a lower trip, die temperature past an upper trip, and a cooled-down indication. From these it produces a switch-on command and an active-low fault flag of the kind that drives an open-drain pin.

Every flag first passes through a synchronizer. Overcurrent and reverse voltage are each qualified by their own timer, which needs the condition to be steady for a full window before the qualified state changes, in both directions. Overcurrent is only reported; the switch keeps conducting because the analog loop already limits current. Reverse voltage, once qualified, also opens the switch. Overtemperature needs no qualification: it opens the switch and raises the fault at once. The switch then stays open until the cool flag is seen, so a lasting overload makes it cycle on and off.

The qualification windows are set in clock cycles by parameters, for example 7.5 ms and 4 ms at the chosen clock rate. Dropping the enable turns the switch off, releases the fault and clears every timer and the thermal latch.

Top module: `psw_supervisor`

## Requirements
- R1: While reset is held, switchOn is 0 and faultN is 1.
- R2: With no condition present, switchOn follows enableIn with a latency of SYNC_STAGES clock edges, in both directions.
- R3: While uvloIn is 1 the switch is held off (SYNC_STAGES edges latency) and faultN is not driven low by it.
- R4: limitIn held at 1 drives faultN to 0 exactly OC_QUAL_CYC + SYNC_STAGES edges after it rises, and switchOn stays 1.
- R5: After limitIn returns to 0, faultN returns to 1 exactly OC_QUAL_CYC + SYNC_STAGES edges later.
- R6: A limitIn pulse shorter than OC_QUAL_CYC cycles never lowers faultN, and a single-cycle gap restarts the count.
- R7: reverseIn held at 1 turns the switch off and lowers faultN after RV_QUAL_CYC + SYNC_STAGES edges; after it clears, both are restored after the same delay; shorter pulses have no effect.
- R8: hotHighIn at 1 turns the switch off and lowers faultN after only the SYNC_STAGES synchronizer edges, whatever the state of limitIn.
- R9: hotLowIn alone is ignored; together with limitIn it acts like R8 with no qualification delay.
- R10: After a thermal shutdown the switch stays off and faultN stays 0 until coolIn is 1; the switch restarts SYNC_STAGES + 1 edges after coolIn rises, and a new trip repeats the cycle.
- R11: enableIn at 0 turns the switch off and releases faultN after SYNC_STAGES edges, and clears the qualification timers and the thermal latch, so a fault still present after re-enable needs a full window again.
- R12: faultN stays 0 while any qualified condition remains, even after another one has cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enableIn | input | 1 | Request to turn the switch on |
| uvloIn | input | 1 | Input supply below the lockout threshold (hysteresis external) |
| limitIn | input | 1 | Switch is in current limit |
| reverseIn | input | 1 | Output voltage above input voltage |
| hotLowIn | input | 1 | Die temperature above the lower trip |
| hotHighIn | input | 1 | Die temperature above the upper trip |
| coolIn | input | 1 | Die has cooled enough to restart |
| switchOn | output | 1 | Command to close the high-side switch |
| faultN | output | 1 | Active-low fault flag |

## Verification
Each result has a fixed latency from the input edge: SYNC_STAGES edges for enable, undervoltage and the thermal trips, SYNC_STAGES + 1 for the restart after the cool flag, and window + SYNC_STAGES for the two qualified conditions. The bench drives inputs on the falling edge and counts falling edges after each change, checking the output one edge before its due time (unchanged) and at its due time (changed). Pulse sweeps on the two qualified inputs cover every length up to one past the window, watching the outputs on every cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;

  // Strobes the control sends to the datapath
  typedef struct packed {
    logic clrOcTimer;
    logic clrRvTimer;
  } pswStrobes_t;

  typedef enum logic {
    TH_RUN = 1'b0,
    TH_OFF = 1'b1
  } thermState_t;

  // Bit positions inside the synchronizer bank
  localparam int IDX_EN    = 0;
  localparam int IDX_UVLO  = 1;
  localparam int IDX_OC    = 2;
  localparam int IDX_RV    = 3;
  localparam int IDX_HOTLO = 4;
  localparam int IDX_HOTHI = 5;
  localparam int IDX_COOL  = 6;
  localparam int NUM_FLAGS = 7;

endpackage

// File: rtl/psw_sync.sv
module psw_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/psw_qual_timer.sv
module psw_qual_timer #(
  parameter int QUAL_CYC = 7500
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic rawIn,
  output logic qualOut
);

  localparam int CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

  logic [CW-1:0] runLen;
  logic          qualState;
  logic          differs;

  assign differs = rawIn != qualState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen    <= '0;
      qualState <= 1'b0;
    end else if (clr) begin
      runLen    <= '0;
      qualState <= 1'b0;
    end else if (!differs) begin
      runLen <= '0;
    end else if (runLen == LAST) begin
      runLen    <= '0;
      qualState <= rawIn;
    end else begin
      runLen <= runLen + 1'b1;
    end
  end

  assign qualOut = qualState;

endmodule

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter int OC_QUAL_CYC = 7500,
  parameter int RV_QUAL_CYC = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enableIn,
  input  logic        uvloIn,
  input  logic        limitIn,
  input  logic        reverseIn,
  input  logic        hotLowIn,
  input  logic        hotHighIn,
  input  logic        coolIn,
  input  pswStrobes_t strobes,
  output logic        enSync,
  output logic        uvloSync,
  output logic        ocSync,
  output logic        rvSync,
  output logic        hotLowSync,
  output logic        hotHighSync,
  output logic        coolSync,
  output logic        ocQual,
  output logic        rvQual
);

  logic [NUM_FLAGS-1:0] rawBank;
  logic [NUM_FLAGS-1:0] syncBank;

  always_comb begin
    rawBank            = '0;
    rawBank[IDX_EN]    = enableIn;
    rawBank[IDX_UVLO]  = uvloIn;
    rawBank[IDX_OC]    = limitIn;
    rawBank[IDX_RV]    = reverseIn;
    rawBank[IDX_HOTLO] = hotLowIn;
    rawBank[IDX_HOTHI] = hotHighIn;
    rawBank[IDX_COOL]  = coolIn;
  end

  psw_sync #(
    .WIDTH (NUM_FLAGS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawBank),
    .syncOut(syncBank)
  );

  assign enSync      = syncBank[IDX_EN];
  assign uvloSync    = syncBank[IDX_UVLO];
  assign ocSync      = syncBank[IDX_OC];
  assign rvSync      = syncBank[IDX_RV];
  assign hotLowSync  = syncBank[IDX_HOTLO];
  assign hotHighSync = syncBank[IDX_HOTHI];
  assign coolSync    = syncBank[IDX_COOL];

  psw_qual_timer #(
    .QUAL_CYC(OC_QUAL_CYC)
  ) u_ocTimer (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (strobes.clrOcTimer),
    .rawIn  (ocSync),
    .qualOut(ocQual)
  );

  psw_qual_timer #(
    .QUAL_CYC(RV_QUAL_CYC)
  ) u_rvTimer (
    .clk    (clk),
    .rstN   (rstN),
    .clr    (strobes.clrRvTimer),
    .rawIn  (rvSync),
    .qualOut(rvQual)
  );

endmodule

// File: rtl/psw_control.sv
module psw_control
  import psw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enSync,
  input  logic        uvloSync,
  input  logic        ocSync,
  input  logic        hotLowSync,
  input  logic        hotHighSync,
  input  logic        coolSync,
  input  logic        ocQual,
  input  logic        rvQual,
  output pswStrobes_t strobes,
  output logic        thermOff,
  output logic        tripNow,
  output logic        switchOn,
  output logic        faultN
);

  thermState_t thState, thNext;
  logic        anyFault;

  // Lower trip counts only while limiting; upper trip always counts
  assign tripNow = hotHighSync | (hotLowSync & ocSync);

  always_comb begin
    thNext = thState;
    if (!enSync) begin
      thNext = TH_RUN;
    end else begin
      case (thState)
        TH_RUN:  if (tripNow) thNext = TH_OFF;
        TH_OFF:  if (coolSync && !tripNow) thNext = TH_RUN;
        default: thNext = TH_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) thState <= TH_RUN;
    else       thState <= thNext;
  end

  assign thermOff = thState == TH_OFF;

  always_comb begin
    strobes            = '0;
    strobes.clrOcTimer = !enSync;
    strobes.clrRvTimer = !enSync;
  end

  assign anyFault = ocQual | rvQual | thermOff | tripNow;
  assign faultN   = !(enSync && anyFault);
  assign switchOn = enSync && !uvloSync && !rvQual && !thermOff && !tripNow;

endmodule

// File: rtl/psw_supervisor.sv
module psw_supervisor
  import psw_pkg::*;
#(
  parameter int OC_QUAL_CYC = 7500,
  parameter int RV_QUAL_CYC = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic enableIn,
  input  logic uvloIn,
  input  logic limitIn,
  input  logic reverseIn,
  input  logic hotLowIn,
  input  logic hotHighIn,
  input  logic coolIn,
  output logic switchOn,
  output logic faultN
);

  pswStrobes_t strobes;
  logic enSync, uvloSync, ocSync, rvSync;
  logic hotLowSync, hotHighSync, coolSync;
  logic ocQual, rvQual, thermOff, tripNow;

  psw_datapath #(
    .OC_QUAL_CYC(OC_QUAL_CYC),
    .RV_QUAL_CYC(RV_QUAL_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .enableIn   (enableIn),
    .uvloIn     (uvloIn),
    .limitIn    (limitIn),
    .reverseIn  (reverseIn),
    .hotLowIn   (hotLowIn),
    .hotHighIn  (hotHighIn),
    .coolIn     (coolIn),
    .strobes    (strobes),
    .enSync     (enSync),
    .uvloSync   (uvloSync),
    .ocSync     (ocSync),
    .rvSync     (rvSync),
    .hotLowSync (hotLowSync),
    .hotHighSync(hotHighSync),
    .coolSync   (coolSync),
    .ocQual     (ocQual),
    .rvQual     (rvQual)
  );

  psw_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .enSync     (enSync),
    .uvloSync   (uvloSync),
    .ocSync     (ocSync),
    .hotLowSync (hotLowSync),
    .hotHighSync(hotHighSync),
    .coolSync   (coolSync),
    .ocQual     (ocQual),
    .rvQual     (rvQual),
    .strobes    (strobes),
    .thermOff   (thermOff),
    .tripNow    (tripNow),
    .switchOn   (switchOn),
    .faultN     (faultN)
  );

endmodule

// File: rtl/psw_supervisor_chk.sv
module psw_supervisor_chk (
  input logic clk,
  input logic rstN,
  input logic switchOn,
  input logic faultN,
  input logic enSync,
  input logic uvloSync,
  input logic ocSync,
  input logic hotHighSync,
  input logic coolSync,
  input logic ocQual,
  input logic rvQual,
  input logic thermOff
);

  AST_UVLO_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rstN)
    uvloSync |-> !switchOn); // R3

  AST_OC_RISE_NEEDS_COND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ocQual) |-> $past(ocSync)); // R4

  AST_OC_FALL_NEEDS_ABSENCE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ocQual) && $past(enSync)) |-> !$past(ocSync)); // R5

  AST_RV_OPENS_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    rvQual |-> !switchOn); // R7

  AST_HOT_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
    (enSync && hotHighSync) |-> (!switchOn && !faultN)); // R8

  AST_RESTART_NEEDS_COOL: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(thermOff) && $past(enSync)) |-> $past(coolSync)); // R10

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enSync |-> (!switchOn && faultN)); // R11

  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (enSync && (ocQual || rvQual)) |-> !faultN); // R12

endmodule

bind psw_supervisor psw_supervisor_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .switchOn   (switchOn),
  .faultN     (faultN),
  .enSync     (enSync),
  .uvloSync   (uvloSync),
  .ocSync     (ocSync),
  .hotHighSync(hotHighSync),
  .coolSync   (coolSync),
  .ocQual     (ocQual),
  .rvQual     (rvQual),
  .thermOff   (thermOff)
);

// File: tb/sim_psw_supervisor.sv
module sim_psw_supervisor;

  localparam int OCW = 12;
  localparam int RVW = 7;
  localparam int SY  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enableIn = 1'b0, uvloIn = 1'b0, limitIn = 1'b0, reverseIn = 1'b0;
  logic hotLowIn = 1'b0, hotHighIn = 1'b0, coolIn = 1'b0;
  logic switchOn, faultN;

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  psw_supervisor #(
    .OC_QUAL_CYC(OCW),
    .RV_QUAL_CYC(RVW),
    .SYNC_STAGES(SY)
  ) u0 (
    .clk(clk), .rstN(rstN), .enableIn(enableIn), .uvloIn(uvloIn),
    .limitIn(limitIn), .reverseIn(reverseIn), .hotLowIn(hotLowIn),
    .hotHighIn(hotHighIn), .coolIn(coolIn), .switchOn(switchOn), .faultN(faultN)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    bit saw;
    wait_n(3);
    chk("R1", "switchOn in reset", switchOn, 1'b0);
    chk("R1", "faultN in reset", faultN, 1'b1);
    rstN = 1'b1;
    wait_n(2);

    // R2: enable latency
    enableIn = 1'b1;
    wait_n(SY - 1);
    chk("R2", "switchOn before due", switchOn, 1'b0);
    wait_n(1);
    chk("R2", "switchOn at due", switchOn, 1'b1);
    chk("R2", "faultN idle", faultN, 1'b1);

    // R3: undervoltage
    uvloIn = 1'b1;
    wait_n(SY);
    chk("R3", "switchOn under uvlo", switchOn, 1'b0);
    chk("R3", "faultN under uvlo", faultN, 1'b1);
    uvloIn = 1'b0;
    wait_n(SY);
    chk("R3", "switchOn after uvlo", switchOn, 1'b1);

    // R4/R5: overcurrent exact latency both ways
    limitIn = 1'b1;
    wait_n(OCW + SY - 1);
    chk("R4", "faultN before window", faultN, 1'b1);
    wait_n(1);
    chk("R4", "faultN at window", faultN, 1'b0);
    chk("R4", "switchOn during limit", switchOn, 1'b1);
    limitIn = 1'b0;
    wait_n(OCW + SY - 1);
    chk("R5", "faultN before release", faultN, 1'b0);
    wait_n(1);
    chk("R5", "faultN at release", faultN, 1'b1);

    // R6: pulse sweep on limitIn
    for (int len = 1; len <= OCW + 1; len++) begin
      saw = 1'b0;
      limitIn = 1'b1;
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        if (!faultN) saw = 1'b1;
      end
      limitIn = 1'b0;
      for (int k = 0; k < SY + 2; k++) begin
        @(negedge clk);
        if (!faultN) saw = 1'b1;
      end
      chk("R6", $sformatf("fault seen for pulse %0d", len), saw, logic'(len >= OCW));
      wait_n(OCW + SY + 2);
      chk("R6", "faultN settled", faultN, 1'b1);
    end
    // R6: a one-cycle gap restarts the count
    saw = 1'b0;
    limitIn = 1'b1;
    for (int k = 0; k < OCW - 1; k++) begin @(negedge clk); if (!faultN) saw = 1'b1; end
    limitIn = 1'b0;
    @(negedge clk);
    limitIn = 1'b1;
    for (int k = 0; k < OCW - 1; k++) begin @(negedge clk); if (!faultN) saw = 1'b1; end
    limitIn = 1'b0;
    for (int k = 0; k < SY + 2; k++) begin @(negedge clk); if (!faultN) saw = 1'b1; end
    chk("R6", "gap restarts count", saw, 1'b0);
    wait_n(4);

    // R7: reverse voltage latency and pulse sweep
    reverseIn = 1'b1;
    wait_n(RVW + SY - 1);
    chk("R7", "switchOn before window", switchOn, 1'b1);
    chk("R7", "faultN before window", faultN, 1'b1);
    wait_n(1);
    chk("R7", "switchOn at window", switchOn, 1'b0);
    chk("R7", "faultN at window", faultN, 1'b0);
    reverseIn = 1'b0;
    wait_n(RVW + SY - 1);
    chk("R7", "switchOn before recovery", switchOn, 1'b0);
    wait_n(1);
    chk("R7", "switchOn at recovery", switchOn, 1'b1);
    chk("R7", "faultN at recovery", faultN, 1'b1);
    for (int len = 1; len <= RVW + 1; len++) begin
      saw = 1'b0;
      reverseIn = 1'b1;
      for (int k = 0; k < len; k++) begin @(negedge clk); if (!switchOn) saw = 1'b1; end
      reverseIn = 1'b0;
      for (int k = 0; k < SY + 2; k++) begin @(negedge clk); if (!switchOn) saw = 1'b1; end
      chk("R7", $sformatf("switch opened for pulse %0d", len), saw, logic'(len >= RVW));
      wait_n(RVW + SY + 2);
      chk("R7", "switchOn settled", switchOn, 1'b1);
    end

    // R8/R10: upper trip, hold, cool restart, repeat
    for (int rep = 0; rep < 2; rep++) begin
      hotHighIn = 1'b1;
      wait_n(SY - 1);
      chk("R8", "switchOn before sync", switchOn, 1'b1);
      wait_n(1);
      chk("R8", "switchOn upper trip", switchOn, 1'b0);
      chk("R8", "faultN upper trip", faultN, 1'b0);
      hotHighIn = 1'b0;
      wait_n(6);
      chk("R10", "switchOn waits for cool", switchOn, 1'b0);
      chk("R10", "faultN waits for cool", faultN, 1'b0);
      coolIn = 1'b1;
      wait_n(SY);
      chk("R10", "switchOn before restart", switchOn, 1'b0);
      wait_n(1);
      chk("R10", "switchOn restart", switchOn, 1'b1);
      chk("R10", "faultN restart", faultN, 1'b1);
      coolIn = 1'b0;
      wait_n(3);
    end

    // R9: lower trip ignored alone, effective with limiting
    hotLowIn = 1'b1;
    wait_n(6);
    chk("R9", "switchOn lower trip alone", switchOn, 1'b1);
    chk("R9", "faultN lower trip alone", faultN, 1'b1);
    limitIn = 1'b1;
    wait_n(SY);
    chk("R9", "switchOn lower trip in limit", switchOn, 1'b0);
    chk("R9", "faultN lower trip in limit", faultN, 1'b0);
    limitIn = 1'b0;
    hotLowIn = 1'b0;
    wait_n(3);
    coolIn = 1'b1;
    wait_n(SY + 1);
    chk("R9", "switchOn after cool", switchOn, 1'b1);
    coolIn = 1'b0;
    wait_n(OCW + 4);
    chk("R9", "faultN after cool", faultN, 1'b1);

    // R12: overlapping qualified faults
    limitIn = 1'b1;
    wait_n(OCW + SY);
    reverseIn = 1'b1;
    wait_n(RVW + SY);
    limitIn = 1'b0;
    wait_n(OCW + SY + 2);
    chk("R12", "faultN held by reverse", faultN, 1'b0);
    reverseIn = 1'b0;
    wait_n(RVW + SY);
    chk("R12", "faultN released", faultN, 1'b1);
    chk("R12", "switchOn restored", switchOn, 1'b1);

    // R11: disable clears timers and fault
    limitIn = 1'b1;
    wait_n(OCW + SY);
    chk("R11", "faultN before disable", faultN, 1'b0);
    enableIn = 1'b0;
    wait_n(SY);
    chk("R11", "switchOn disabled", switchOn, 1'b0);
    chk("R11", "faultN disabled", faultN, 1'b1);
    wait_n(3);
    enableIn = 1'b1;
    wait_n(SY);
    chk("R11", "switchOn re-enabled", switchOn, 1'b1);
    wait_n(OCW - 1);
    chk("R11", "faultN fresh window not done", faultN, 1'b1);
    wait_n(1);
    chk("R11", "faultN fresh window done", faultN, 1'b0);
    limitIn = 1'b0;
    wait_n(OCW + SY + 2);
    // R11: disable clears thermal latch
    hotHighIn = 1'b1;
    wait_n(SY);
    hotHighIn = 1'b0;
    wait_n(3);
    chk("R11", "switchOn latched off", switchOn, 1'b0);
    enableIn = 1'b0;
    wait_n(4);
    enableIn = 1'b1;
    wait_n(SY);
    chk("R11", "switchOn latch cleared", switchOn, 1'b1);
    chk("R11", "faultN latch cleared", faultN, 1'b1);

    done = 1'b1;
    finish_run();
  end

endmodule